// File: doc/BRIEF.md
# Accumulating Bit-Logic Execution Unit

This unit decodes and executes one family of 32-bit instructions. Each instruction picks one bit from each of two source registers and combines the pair with one of four two-input functions: AND, OR, NOR, or AND with the second bit inverted. The result is ORed into bit 0 of a destination register. Bits 31 down to 1 of that register keep their old value. Once bit 0 of a register is set, these instructions cannot clear it. This makes the unit useful for building up a condition from many bit tests.

The unit holds a 16 x 32-bit register file. The register file has three internal read ports (source a, source b and the old destination value) and one combinational read port for checking results. A single-cycle decoder feeds the bit-select and combine datapath, and the result is written back on the next rising edge. A direct load port writes registers for test setup.

Instructions arrive on a valid/ready port. An instruction is taken when `ins_valid` and `ins_ready` are both high in the same cycle. The `ins_ready` signal is low in any cycle where the load port is active. A source holding `ins_valid` must keep `ins_word` stable until it is taken. Nothing else stalls the unit, so the unit never holds back an instruction when no load is in progress.

Top module: `bitacc_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all 16 registers to zero.
- R2: `rd_data` always shows the current content of register `rd_idx`, with no clock delay.
- R3: While `ld_en` is high, the rising edge writes `ld_data` into register `ld_idx`. In that cycle `ins_ready` is low, no instruction is taken, and `ill_flag` stays low.
- R4: An instruction is taken only in a cycle where both `ins_valid` and `ins_ready` are high. A word presented with `ins_valid` low changes no register.
- R5: The word fields are: destination index c in bits 31:28, second bit position in 27:23, function code in 22:21, first bit position in 20:16, source b in 15:12, source a in 11:8, and major opcode in 7:0. Only major opcode 0xC7 is legal. When a taken word has any other opcode, `ill_flag` is high in that same cycle and no register is written.
- R6: Function code 00 combines the bits as a[pos1] AND b[pos2].
- R7: Function code 01 combines the bits as a[pos1] OR b[pos2].
- R8: Function code 10 combines the bits as NOT (a[pos1] OR b[pos2]).
- R9: Function code 11 combines the bits as a[pos1] AND NOT b[pos2].
- R10: After a legal taken instruction, the new bit 0 of register c equals its old bit 0 ORed with the combined bit. A set bit 0 therefore stays set.
- R11: A legal instruction leaves bits 31:1 of register c, and every other register, unchanged.
- R12: Sources and the old destination are all read before the write. When c equals a or b, the pre-instruction value is used in every case.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Instruction word is offered |
| ins_ready | output | 1 | Unit will take the offered word this cycle |
| ins_word | input | 32 | Instruction word |
| ill_flag | output | 1 | Taken word has an unknown major opcode (same cycle) |
| ld_en | input | 1 | Direct register load strobe |
| ld_idx | input | 4 | Register index for the load |
| ld_data | input | 32 | Value to load |
| rd_idx | input | 4 | Register index for the check read port |
| rd_data | output | 32 | Content of register rd_idx |

## Verification
The embedded assertions check several properties on every cycle:
- a set bit 0 survives into the write data;
- the upper 31 bits of the write data match the old destination;
- an illegal word never writes;
- a load blocks instruction intake;
- every register write lands;
- reset clears all entries.

Only the bench scenarios can show the following behaviours:
- the truth table of each of the four functions, with bits taken from arbitrary positions;
- correct source and destination selection, including aliasing of c with a or b;
- the absence of writes when `ins_valid` is low.

// File: rtl/bitacc_pkg.sv
package bitacc_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 16;
  localparam int IDXW = $clog2(NREG);
  localparam int POSW = $clog2(XLEN);
  localparam logic [7:0] MAJOR_OP = 8'hC7;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOR  = 2'b10,
    FN_ANDN = 2'b11
  } fn_e;

  typedef struct packed {
    logic            legal;
    fn_e             fn;
    logic [IDXW-1:0] dst;
    logic [IDXW-1:0] srca;
    logic [IDXW-1:0] srcb;
    logic [POSW-1:0] pa;
    logic [POSW-1:0] pb;
  } dec_t;
endpackage

// File: rtl/bitacc_decode.sv
module bitacc_decode
  import bitacc_pkg::*;
(
  input  logic [31:0] word,
  output dec_t        dec
);
  localparam int OP_LSB  = 0;
  localparam int A_LSB   = 8;
  localparam int B_LSB   = A_LSB + IDXW;
  localparam int PA_LSB  = B_LSB + IDXW;
  localparam int FN_LSB  = PA_LSB + POSW;
  localparam int PB_LSB  = FN_LSB + 2;
  localparam int DST_LSB = PB_LSB + POSW;

  always_comb begin
    dec.legal = (word[OP_LSB +: 8] == MAJOR_OP);
    dec.fn    = fn_e'(word[FN_LSB +: 2]);
    dec.dst   = word[DST_LSB +: IDXW];
    dec.srca  = word[A_LSB +: IDXW];
    dec.srcb  = word[B_LSB +: IDXW];
    dec.pa    = word[PA_LSB +: POSW];
    dec.pb    = word[PB_LSB +: POSW];
  end
endmodule

// File: rtl/bitacc_regfile.sv
module bitacc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output logic [XLEN-1:0] rb_data,
  input  logic [IDXW-1:0] rc_idx,
  output logic [XLEN-1:0] rc_data,
  input  logic [IDXW-1:0] rx_idx,
  output logic [XLEN-1:0] rx_data,
  input  logic            we,
  input  logic [IDXW-1:0] waddr,
  input  logic [XLEN-1:0] wdata
);
  logic [XLEN-1:0] mem_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign ra_data = mem_q[ra_idx];
  assign rb_data = mem_q[rb_idx];
  assign rc_data = mem_q[rc_idx];
  assign rx_data = mem_q[rx_idx];

  // R3 R10 R11
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> mem_q[$past(waddr)] == $past(wdata));

  for (genvar g = 0; g < NREG; g++) begin : g_rst
    // R1
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> mem_q[g] == '0);
  end
endmodule

// File: rtl/bitacc_combine.sv
module bitacc_combine
  import bitacc_pkg::*;
(
  input  logic [XLEN-1:0] a_word,
  input  logic [XLEN-1:0] b_word,
  input  logic [POSW-1:0] pa,
  input  logic [POSW-1:0] pb,
  input  fn_e             fn,
  input  logic [XLEN-1:0] c_old,
  output logic [XLEN-1:0] c_new
);
  logic x_bit, y_bit, f_bit;

  assign x_bit = a_word[pa];
  assign y_bit = b_word[pb];

  always_comb begin
    unique case (fn)
      FN_AND:  f_bit = x_bit & y_bit;
      FN_OR:   f_bit = x_bit | y_bit;
      FN_NOR:  f_bit = ~(x_bit | y_bit);
      FN_ANDN: f_bit = x_bit & ~y_bit;
      default: f_bit = 1'b0;
    endcase
  end

  assign c_new = {c_old[XLEN-1:1], c_old[0] | f_bit};
endmodule

// File: rtl/bitacc_unit.sv
module bitacc_unit
  import bitacc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            ins_valid,
  output logic            ins_ready,
  input  logic [31:0]     ins_word,
  output logic            ill_flag,
  input  logic            ld_en,
  input  logic [IDXW-1:0] ld_idx,
  input  logic [XLEN-1:0] ld_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [XLEN-1:0] rd_data
);
  dec_t            dec;
  logic            accept, exec_we, rf_we;
  logic [IDXW-1:0] rf_waddr;
  logic [XLEN-1:0] rf_wdata, a_word, b_word, c_old, c_new;

  bitacc_decode u_dec (.word(ins_word), .dec(dec));

  bitacc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .ra_idx(dec.srca), .ra_data(a_word),
    .rb_idx(dec.srcb), .rb_data(b_word),
    .rc_idx(dec.dst),  .rc_data(c_old),
    .rx_idx(rd_idx),   .rx_data(rd_data),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata)
  );

  bitacc_combine u_cmb (
    .a_word(a_word), .b_word(b_word), .pa(dec.pa), .pb(dec.pb),
    .fn(dec.fn), .c_old(c_old), .c_new(c_new)
  );

  assign ins_ready = ~ld_en;
  assign accept    = ins_valid & ins_ready;
  assign ill_flag  = accept & ~dec.legal;
  assign exec_we   = accept & dec.legal;
  assign rf_we     = ld_en | exec_we;
  assign rf_waddr  = ld_en ? ld_idx : dec.dst;
  assign rf_wdata  = ld_en ? ld_data : c_new;

  // R10
  sticky_bit0_chk: assert property (@(posedge clk) disable iff (rst)
    (exec_we && c_old[0]) |-> rf_wdata[0]);

  // R11
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    exec_we |-> rf_wdata[XLEN-1:1] == c_old[XLEN-1:1]);

  // R3
  load_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> (!ins_ready && !ill_flag && rf_waddr == ld_idx));

  // R5
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    ill_flag |-> !rf_we);
endmodule

// File: tb/bitacc_unit_bench.sv
`timescale 1ns/1ps
module bitacc_unit_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        ins_valid = 0;
  logic        ins_ready;
  logic [31:0] ins_word = '0;
  logic        ill_flag;
  logic        ld_en = 0;
  logic [3:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [16];

  always #2 clk = ~clk;

  bitacc_unit u_bitacc_unit (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .ill_flag(ill_flag), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  function automatic logic fn_ref(logic [1:0] s, logic x, logic y);
    case (s)
      2'd0: return x & y;
      2'd1: return x | y;
      2'd2: return ~(x | y);
      default: return x & ~y;
    endcase
  endfunction

  function automatic logic [31:0] mk(int c, int p2, int s, int p1, int b, int a, logic [7:0] op);
    return {c[3:0], p2[4:0], s[1:0], p1[4:0], b[3:0], a[3:0], op};
  endfunction

  function automatic void model_exec(logic [31:0] w);
    logic x, y;
    if (w[7:0] != 8'hC7) return;
    x = model[w[11:8]][w[20:16]];
    y = model[w[15:12]][w[27:23]];
    model[w[31:28]][0] = model[w[31:28]][0] | fn_ref(w[22:21], x, y);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_check(input int idx, input string req);
    rd_idx = idx[3:0];
    #1;
    chk(rd_data === model[idx], req, rd_data, model[idx]);
  endtask

  task automatic all_check(input string req);
    for (int i = 0; i < 16; i++) rd_check(i, req);
  endtask

  task automatic do_load(input int idx, input logic [31:0] v);
    @(negedge clk);
    ld_en = 1; ld_idx = idx[3:0]; ld_data = v;
    @(posedge clk);
    model[idx] = v;
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic do_exec(input logic [31:0] w, input string req);
    logic exp_ill;
    exp_ill = (w[7:0] != 8'hC7);
    @(negedge clk);
    ins_valid = 1; ins_word = w;
    #1;
    chk(ill_flag === exp_ill && ins_ready === 1'b1, "R5 ill_flag", {31'd0, ill_flag}, {31'd0, exp_ill});
    @(posedge clk);
    model_exec(w);
    @(negedge clk);
    ins_valid = 0;
    rd_check(w[31:28], req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) model[i] = '0;
    // R1 R2: reset clears everything
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    all_check("R1 reset");

    // R3 R2: direct loads
    for (int i = 0; i < 16; i++) do_load(i, $urandom);
    all_check("R3 load");

    // R6 R7 R8 R9: full truth table per function, dest r5 bit0 cleared
    for (int s = 0; s < 4; s++) begin
      for (int xy = 0; xy < 4; xy++) begin
        do_load(1, xy[1] ? 32'h0000_0100 : 32'h0);
        do_load(2, xy[0] ? 32'h0008_0000 : 32'h0);
        do_load(5, 32'hA5A5_5A5A);
        w = mk(5, 19, s, 8, 2, 1, 8'hC7);
        case (s)
          0: do_exec(w, "R6 and");
          1: do_exec(w, "R7 or");
          2: do_exec(w, "R8 nor");
          default: do_exec(w, "R9 andn");
        endcase
        chk(rd_data[0] === fn_ref(s[1:0], xy[1], xy[0]), "R6 R7 R8 R9 literal",
            {31'd0, rd_data[0]}, {31'd0, fn_ref(s[1:0], xy[1], xy[0])});
      end
    end

    // R10: set bit 0 stays set when function yields 0
    do_load(7, 32'hFFFF_0001);
    do_load(1, 32'h0); do_load(2, 32'h0);
    do_exec(mk(7, 0, 0, 0, 2, 1, 8'hC7), "R10 sticky");
    chk(rd_data === 32'hFFFF_0001, "R10 sticky literal", rd_data, 32'hFFFF_0001);
    // R11: upper bits untouched, other registers untouched
    do_load(8, 32'hDEAD_BEEE);
    do_load(1, 32'hFFFF_FFFF);
    do_exec(mk(8, 3, 1, 31, 1, 1, 8'hC7), "R11 upper");
    chk(rd_data === 32'hDEAD_BEEF, "R11 upper literal", rd_data, 32'hDEAD_BEEF);
    all_check("R11 others");

    // R12: c aliases a (pos1 = 0 reads old bit 0)
    do_load(4, 32'h0000_0002);
    do_exec(mk(4, 1, 2, 0, 4, 4, 8'hC7), "R12 alias");
    chk(rd_data === 32'h0000_0002, "R12 alias literal", rd_data, 32'h0000_0002);
    do_exec(mk(4, 1, 0, 1, 4, 4, 8'hC7), "R12 alias and");
    chk(rd_data === 32'h0000_0003, "R12 alias and literal", rd_data, 32'h0000_0003);

    // R5: illegal opcode writes nothing
    for (int i = 0; i < 16; i++) do_load(i, 32'h0);
    do_exec(mk(3, 0, 2, 0, 0, 0, 8'hC6), "R5 illegal");
    all_check("R5 illegal no write");

    // R4: valid low has no effect
    @(negedge clk);
    ins_valid = 0; ins_word = mk(3, 0, 2, 0, 0, 0, 8'hC7);
    @(posedge clk); @(negedge clk);
    rd_check(3, "R4 no valid");

    // R3 R4: load holds off an instruction
    @(negedge clk);
    ins_valid = 1; ins_word = mk(6, 0, 2, 0, 0, 0, 8'h00);
    ld_en = 1; ld_idx = 4'd9; ld_data = 32'h1234_5678;
    #1;
    chk(ins_ready === 1'b0 && ill_flag === 1'b0, "R3 backpressure",
        {30'd0, ins_ready, ill_flag}, 32'd0);
    @(posedge clk);
    model[9] = 32'h1234_5678;
    @(negedge clk);
    ld_en = 0; ins_valid = 0;
    all_check("R3 R4 load priority");

    // random mix
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 16) == 0) do_load($urandom % 16, $urandom & 32'hFFFF_FFFE);
      w = $urandom;
      w[7:0] = (($urandom % 8) == 0) ? 8'h3C : 8'hC7;
      do_exec(w, "R10 random");
      if ((n % 50) == 49) all_check("R11 random sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule